// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared register set of a multi-channel event timer: a read-only capability word, a general configuration word, and a 64-bit main counter. Software reaches all of it through a 32-bit memory-mapped port. Accesses that fall in the per-channel window are not handled here. They are decoded to a channel index and a word offset and handed to the channel slots, which sit outside this block.

The capability word tells software two things. Its upper half gives the tick period in femtoseconds. Its lower half holds a fixed identity pattern, and the number of implemented channels is placed inside that pattern. The main counter advances by one on every clock while the enable bit is set. It freezes when the bit is cleared, and software may then load it half by half. The block exports the counter value, the enable and legacy bits, and one-cycle pulses on the enable edges. A rising edge asks each channel whose comparator is not at its all-ones idle value to re-arm. A falling edge tells every channel to disarm.

Top module: `evt_gblk`

## Requirements
- R1: The word at byte offset 0x000 reads 0x8086A001 with (NT-1) ORed into bits 12:8. NT is NUM_TIMERS raised to at least 3 and limited to at most MAX_TIMERS.
- R2: The word at offset 0x004 reads the TICK_FS parameter, which is the tick period in femtoseconds.
- R3: The configuration word at 0x010 keeps bit 0 (enable) and bit 1 (legacy), and all its other bits read 0. The word at 0x014 always reads 0 and ignores writes.
- R4: While enable is 1, the 64-bit counter increases by exactly 1 on every clock, and the carry passes from the low half into the high half.
- R5: While enable is 0, the counter holds its value. Reads of 0x0F0 (low half) and 0x0F4 (high half) return that frozen value.
- R6: A write to 0x0F0 or 0x0F4 replaces that half of the counter while enable is 0. The same write is ignored while enable is 1.
- R7: A write that changes enable from 0 to 1 raises rearm_o[i] for one cycle for each channel i whose cmp_max_i[i] is 0. A write that changes enable from 1 to 0 raises every disarm_o bit for one cycle. Writing the value enable already holds raises no pulse.
- R8: An access to byte addresses 0x100 to 0x3FF selects slot (addr-0x100)/32 and word offset addr[4:0]. slot_req_o carries a one-hot strobe during the request cycle, with the write flag and write data passed through. A read returns that slot's 32-bit lane of slot_rdata_i, where lane i is bits [32i+31:32i].
- R9: An access to a slot index of NT or above raises no strobe and reads 0.
- R10: After reset, the counter, enable and legacy are 0 and no pulses are active. Every read request is answered with rd_valid_o high on the next cycle, with the data in rd_data_o. Unmapped addresses and addresses with addr[1:0] not equal to 0 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 32 | Read data |
| slot_req_o | output | NT | One-hot channel slot strobe |
| slot_write_o | output | 1 | Write flag forwarded to slots |
| slot_off_o | output | 5 | Byte offset inside the slot |
| slot_wdata_o | output | 32 | Write data forwarded to slots |
| slot_rdata_i | input | 32*NT | Read data lanes from the slots |
| cmp_max_i | input | NT | Per channel: comparator holds its all-ones idle value |
| count_o | output | 64 | Main counter value |
| enable_o | output | 1 | Global enable bit |
| legacy_o | output | 1 | Legacy routing bit |
| rearm_o | output | NT | One-cycle re-arm pulse per channel |
| disarm_o | output | NT | One-cycle disarm pulse per channel |

## Verification
The counter is loaded just below a 32-bit boundary and run for a known number of cycles, so the exact result shows that the carry crosses into the high half. A counter write placed between an enable and a disable gives a different final value depending on whether the write was dropped or applied. A per-channel comparator mask with mixed bits separates the selective re-arm pulse from the all-channel disarm pulse, and repeating an enable write shows that only a real edge makes a pulse. Slot addresses inside the implemented range, just past it, and at the top of the window separate correct forwarding from an off-by-one in the slot limit.

// File: rtl/evt_gblk_pkg.sv
package evt_gblk_pkg;

   localparam int unsigned MIN_TIMERS   = 3;
   localparam int unsigned WORD_W       = 32;
   localparam int unsigned SLOT_BYTES   = 32;
   localparam logic [31:0] CAP_PATTERN  = 32'h8086_A001;
   localparam int unsigned NT_FIELD_LSB = 8;
   localparam int unsigned NT_FIELD_W   = 5;

   localparam int unsigned OFS_CAP_LO  = 'h000;
   localparam int unsigned OFS_CAP_HI  = 'h004;
   localparam int unsigned OFS_CFG_LO  = 'h010;
   localparam int unsigned OFS_CFG_HI  = 'h014;
   localparam int unsigned OFS_CNT_LO  = 'h0F0;
   localparam int unsigned OFS_CNT_HI  = 'h0F4;
   localparam int unsigned OFS_SLOT_LO = 'h100;
   localparam int unsigned OFS_SLOT_HI = 'h3FF;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CAP_LO,
      SEL_CAP_HI,
      SEL_CFG_LO,
      SEL_CFG_HI,
      SEL_CNT_LO,
      SEL_CNT_HI,
      SEL_SLOT
   } reg_sel_e;

   function automatic int unsigned clamp_timers(int unsigned req, int unsigned hi);
      if (req < MIN_TIMERS) return MIN_TIMERS;
      if (req > hi) return hi;
      return req;
   endfunction

   function automatic logic [31:0] cap_low_word(int unsigned nt);
      logic [31:0] fld;
      fld = 32'(nt - 1) << NT_FIELD_LSB;
      return CAP_PATTERN | fld;
   endfunction

endpackage

// File: rtl/evt_gblk_dec.sv
module evt_gblk_dec
   import evt_gblk_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned NT     = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o,
   output logic [NT-1:0]     slot_hit_o,
   output logic [4:0]        slot_off_o
);

   localparam int unsigned IDX_W    = ADDR_W - 5;
   localparam int unsigned SLOT_BASE = OFS_SLOT_LO / SLOT_BYTES;

   logic              aligned;
   logic              in_window;
   logic [IDX_W-1:0]  slot_idx;

   assign aligned    = (addr_i[1:0] == 2'b00);
   assign in_window  = (addr_i >= ADDR_W'(OFS_SLOT_LO)) && (addr_i <= ADDR_W'(OFS_SLOT_HI));
   assign slot_idx   = addr_i[ADDR_W-1:5] - IDX_W'(SLOT_BASE);
   assign slot_off_o = addr_i[4:0];

   always_comb begin
      sel_o = SEL_NONE;
      if (aligned) begin
         if (in_window) begin
            sel_o = SEL_SLOT;
         end else begin
            case (addr_i)
               ADDR_W'(OFS_CAP_LO): sel_o = SEL_CAP_LO;
               ADDR_W'(OFS_CAP_HI): sel_o = SEL_CAP_HI;
               ADDR_W'(OFS_CFG_LO): sel_o = SEL_CFG_LO;
               ADDR_W'(OFS_CFG_HI): sel_o = SEL_CFG_HI;
               ADDR_W'(OFS_CNT_LO): sel_o = SEL_CNT_LO;
               ADDR_W'(OFS_CNT_HI): sel_o = SEL_CNT_HI;
               default:             sel_o = SEL_NONE;
            endcase
         end
      end
   end

   for (genvar i = 0; i < NT; i++) begin : g_slot
      assign slot_hit_o[i] = aligned && in_window && (slot_idx == IDX_W'(i));
   end

   // R8
   always_comb begin
      slot_onehot_chk: assert ($onehot0(slot_hit_o));
   end

   // R9
   always_comb begin
      slot_window_chk: assert (in_window || (slot_hit_o == '0));
   end

endmodule

// File: rtl/evt_gblk_cnt.sv
module evt_gblk_cnt
   import evt_gblk_pkg::*;
#(
   parameter int unsigned HALF_W = WORD_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [HALF_W-1:0] wdata_i,
   output logic [2*HALF_W-1:0] cnt_o
);

   localparam int unsigned CNT_W = 2 * HALF_W;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (wr_lo_i) begin
         cnt_q[HALF_W-1:0] <= wdata_i;
      end else if (wr_hi_i) begin
         cnt_q[CNT_W-1:HALF_W] <= wdata_i;
      end
   end

   assign cnt_o = cnt_q;

   // R4 R6
   count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R5
   count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));

   // R6
   count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && wr_hi_i && !wr_lo_i) |=> (cnt_q[CNT_W-1:HALF_W] == $past(wdata_i)));

endmodule

// File: rtl/evt_gblk_cfg.sv
module evt_gblk_cfg #(
   parameter int unsigned NT = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic [1:0]    wbits_i,
   input  logic [NT-1:0] cmp_max_i,
   output logic          en_o,
   output logic          leg_o,
   output logic [NT-1:0] rearm_o,
   output logic [NT-1:0] disarm_o
);

   logic en_q, leg_q, rise_q, fall_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         leg_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         rise_q <= wr_i && wbits_i[0] && !en_q;
         fall_q <= wr_i && !wbits_i[0] && en_q;
         if (wr_i) begin
            en_q  <= wbits_i[0];
            leg_q <= wbits_i[1];
         end
      end
   end

   for (genvar i = 0; i < NT; i++) begin : g_chan
      assign rearm_o[i]  = rise_q && !cmp_max_i[i];
      assign disarm_o[i] = fall_q;
   end

   assign en_o  = en_q;
   assign leg_o = leg_q;

   // R7
   rearm_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q) |-> rise_q);

   // R7
   disarm_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_q) |-> fall_q);

   // R7
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_q || fall_q) |=> !(rise_q || fall_q));

   // R7
   rearm_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rearm_o != '0) |-> en_q);

endmodule

// File: rtl/evt_gblk.sv
module evt_gblk
   import evt_gblk_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned NUM_TIMERS = 3,
   parameter int unsigned MAX_TIMERS = 32,
   parameter int unsigned TICK_FS    = 10_000_000,
   localparam int unsigned NT        = clamp_timers(NUM_TIMERS, MAX_TIMERS)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [31:0]        req_wdata_i,
   output logic               rd_valid_o,
   output logic [31:0]        rd_data_o,
   output logic [NT-1:0]      slot_req_o,
   output logic               slot_write_o,
   output logic [4:0]         slot_off_o,
   output logic [31:0]        slot_wdata_o,
   input  logic [NT*32-1:0]   slot_rdata_i,
   input  logic [NT-1:0]      cmp_max_i,
   output logic [63:0]        count_o,
   output logic               enable_o,
   output logic               legacy_o,
   output logic [NT-1:0]      rearm_o,
   output logic [NT-1:0]      disarm_o
);

   localparam logic [31:0] CAP_LO = cap_low_word(NT);
   localparam logic [31:0] CAP_HI = 32'(TICK_FS);

   if (ADDR_W < 10) begin : g_bad_addr
      $error("evt_gblk: ADDR_W must cover the slot window");
   end
   if (MAX_TIMERS < MIN_TIMERS || MAX_TIMERS > (1 << NT_FIELD_W)) begin : g_bad_max
      $error("evt_gblk: MAX_TIMERS out of range");
   end
   if (TICK_FS == 0) begin : g_bad_tick
      $error("evt_gblk: TICK_FS must be nonzero");
   end

   reg_sel_e          sel;
   logic [NT-1:0]     slot_hit;
   logic              wr_req, rd_req;
   logic [31:0]       slot_lane;
   logic [31:0]       rd_next;
   logic              rd_valid_q;
   logic [31:0]       rd_data_q;

   assign wr_req = req_valid_i && req_write_i;
   assign rd_req = req_valid_i && !req_write_i;

   evt_gblk_dec #(
      .ADDR_W (ADDR_W),
      .NT     (NT)
   ) i_dec (
      .addr_i     (req_addr_i),
      .sel_o      (sel),
      .slot_hit_o (slot_hit),
      .slot_off_o (slot_off_o)
   );

   evt_gblk_cnt #(
      .HALF_W (WORD_W)
   ) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (enable_o),
      .wr_lo_i (wr_req && (sel == SEL_CNT_LO)),
      .wr_hi_i (wr_req && (sel == SEL_CNT_HI)),
      .wdata_i (req_wdata_i),
      .cnt_o   (count_o)
   );

   evt_gblk_cfg #(
      .NT (NT)
   ) i_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_req && (sel == SEL_CFG_LO)),
      .wbits_i   (req_wdata_i[1:0]),
      .cmp_max_i (cmp_max_i),
      .en_o      (enable_o),
      .leg_o     (legacy_o),
      .rearm_o   (rearm_o),
      .disarm_o  (disarm_o)
   );

   assign slot_req_o   = req_valid_i ? slot_hit : '0;
   assign slot_write_o = req_write_i;
   assign slot_wdata_o = req_wdata_i;

   always_comb begin
      slot_lane = '0;
      for (int i = 0; i < NT; i++) begin
         if (slot_hit[i]) slot_lane = slot_lane | slot_rdata_i[i*32 +: 32];
      end
   end

   always_comb begin
      case (sel)
         SEL_CAP_LO: rd_next = CAP_LO;
         SEL_CAP_HI: rd_next = CAP_HI;
         SEL_CFG_LO: rd_next = {30'b0, legacy_o, enable_o};
         SEL_CNT_LO: rd_next = count_o[31:0];
         SEL_CNT_HI: rd_next = count_o[63:32];
         SEL_SLOT:   rd_next = slot_lane;
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= rd_req;
         if (rd_req) rd_data_q <= rd_next;
      end
   end

   assign rd_valid_o = rd_valid_q;
   assign rd_data_o  = rd_data_q;

   // R10
   read_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req |=> rd_valid_o);

   // R10
   read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_req |=> !rd_valid_o);

   // R1
   read_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req && sel == SEL_CAP_LO) |=> (rd_data_o[NT_FIELD_LSB +: NT_FIELD_W] == NT_FIELD_W'(NT - 1)));

   // R8
   strobe_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |-> (slot_req_o == '0));

endmodule

// File: tb/test_evt_gblk.sv
`timescale 1ns/1ps
module test_evt_gblk;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid = 1'b0;
   logic         write = 1'b0;
   logic [9:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [2:0]   cmp_max = 3'b010;
   logic [95:0]  slot_rdata = {32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};

   logic         rd_valid;
   logic [31:0]  rd_data;
   logic [2:0]   slot_req;
   logic         slot_write;
   logic [4:0]   slot_off;
   logic [31:0]  slot_wdata;
   logic [63:0]  count;
   logic         enable, legacy;
   logic [2:0]   rearm, disarm;

   logic         c_rd_valid;
   logic [31:0]  c_rd_data;
   logic [7:0]   c_slot_req;
   logic         c_slot_write;
   logic [4:0]   c_slot_off;
   logic [31:0]  c_slot_wdata;
   logic [63:0]  c_count;
   logic         c_enable, c_legacy;
   logic [7:0]   c_rearm, c_disarm;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   evt_gblk #(.ADDR_W(10), .NUM_TIMERS(3), .MAX_TIMERS(32), .TICK_FS(10_000_000)) i_evt_gblk (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
      .req_addr_i(addr), .req_wdata_i(wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
      .slot_req_o(slot_req), .slot_write_o(slot_write), .slot_off_o(slot_off),
      .slot_wdata_o(slot_wdata), .slot_rdata_i(slot_rdata), .cmp_max_i(cmp_max),
      .count_o(count), .enable_o(enable), .legacy_o(legacy),
      .rearm_o(rearm), .disarm_o(disarm));

   evt_gblk #(.ADDR_W(10), .NUM_TIMERS(40), .MAX_TIMERS(8), .TICK_FS(10_000_000)) i_evt_gblk_clamp (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
      .req_addr_i(addr), .req_wdata_i(wdata), .rd_valid_o(c_rd_valid), .rd_data_o(c_rd_data),
      .slot_req_o(c_slot_req), .slot_write_o(c_slot_write), .slot_off_o(c_slot_off),
      .slot_wdata_o(c_slot_wdata), .slot_rdata_i(256'd0), .cmp_max_i(8'd0),
      .count_o(c_count), .enable_o(c_enable), .legacy_o(c_legacy),
      .rearm_o(c_rearm), .disarm_o(c_disarm));

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      valid = 1'b0; write = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic [31:0] dc);
      @(negedge clk);
      valid = 1'b1; write = 1'b0; addr = a;
      @(negedge clk);
      valid = 1'b0;
      chk("R10", "read valid", 64'(rd_valid), 64'd1);
      d = rd_data; dc = c_rd_data;
   endtask

   task automatic t_reset;
      logic [31:0] d, dc;
      chk("R10", "counter after reset", count, 64'd0);
      chk("R10", "enable after reset", 64'(enable), 64'd0);
      chk("R10", "pulses after reset", 64'({rearm, disarm}), 64'd0);
      rd(10'h010, d, dc);
      chk("R10", "config after reset", 64'(d), 64'd0);
   endtask

   task automatic t_capability;
      logic [31:0] d, dc;
      rd(10'h000, d, dc);
      chk("R1", "cap low, 3 timers", 64'(d), 64'h8086_A201);
      chk("R1", "cap low, clamped to 8", 64'(dc), 64'h8086_A701);
      rd(10'h004, d, dc);
      chk("R2", "cap high period", 64'(d), 64'h0098_9680);
   endtask

   task automatic t_config;
      logic [31:0] d, dc;
      wr(10'h010, 32'hFFFF_FFFE);
      chk("R3", "legacy out", 64'(legacy), 64'd1);
      chk("R3", "enable out", 64'(enable), 64'd0);
      rd(10'h010, d, dc);
      chk("R3", "config readback", 64'(d), 64'h2);
      wr(10'h014, 32'hFFFF_FFFF);
      rd(10'h014, d, dc);
      chk("R3", "config high reads zero", 64'(d), 64'd0);
      rd(10'h010, d, dc);
      chk("R3", "config unchanged by high write", 64'(d), 64'h2);
   endtask

   task automatic t_count_run;
      logic [31:0] d, dc;
      wr(10'h0F0, 32'hFFFF_FFFE);
      wr(10'h0F4, 32'h0000_0001);
      rd(10'h0F0, d, dc);
      chk("R6", "loaded low half", 64'(d), 64'hFFFF_FFFE);
      rd(10'h0F4, d, dc);
      chk("R6", "loaded high half", 64'(d), 64'h1);
      wr(10'h010, 32'h1);
      chk("R7", "rearm on rising enable", 64'(rearm), 64'b101);
      chk("R7", "no disarm on rising enable", 64'(disarm), 64'd0);
      @(negedge clk);
      chk("R7", "rearm lasts one cycle", 64'(rearm), 64'd0);
      wr(10'h010, 32'h0);
      chk("R7", "disarm on falling enable", 64'(disarm), 64'b111);
      chk("R4", "counter carry into high half", count, 64'h2_0000_0001);
      @(negedge clk);
      chk("R7", "disarm lasts one cycle", 64'(disarm), 64'd0);
   endtask

   task automatic t_frozen;
      logic [31:0] d, dc, d2;
      rd(10'h0F0, d, dc);
      repeat (5) @(negedge clk);
      rd(10'h0F0, d2, dc);
      chk("R5", "frozen low half", 64'(d2), 64'h1);
      chk("R5", "frozen repeat read", 64'(d2), 64'(d));
      rd(10'h0F4, d, dc);
      chk("R5", "frozen high half", 64'(d), 64'h2);
   endtask

   task automatic t_write_running;
      logic [31:0] d, dc;
      wr(10'h010, 32'h1);
      wr(10'h0F0, 32'h0);
      wr(10'h010, 32'h0);
      rd(10'h0F0, d, dc);
      chk("R6", "low write ignored while enabled", 64'(d), 64'h5);
   endtask

   task automatic t_same_value;
      logic [31:0] d1, d2, dc;
      wr(10'h010, 32'h1);
      chk("R7", "rearm on new enable", 64'(rearm), 64'b101);
      wr(10'h010, 32'h1);
      chk("R7", "no rearm on repeated enable", 64'(rearm), 64'd0);
      chk("R7", "enable still set", 64'(enable), 64'd1);
      rd(10'h0F0, d1, dc);
      rd(10'h0F0, d2, dc);
      chk("R4", "running counter step between reads", 64'(d2 - d1), 64'd2);
      wr(10'h010, 32'h0);
      chk("R7", "disarm after repeated enable", 64'(disarm), 64'b111);
   endtask

   task automatic t_slots;
      logic [31:0] d, dc;
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = 10'h128; wdata = 32'hA5A5_0128;
      #1;
      chk("R8", "slot strobe for 0x128", 64'(slot_req), 64'b010);
      chk("R8", "slot offset", 64'(slot_off), 64'h08);
      chk("R8", "slot write flag", 64'(slot_write), 64'd1);
      chk("R8", "slot write data", 64'(slot_wdata), 64'hA5A5_0128);
      addr = 10'h160;
      #1;
      chk("R9", "no strobe past count", 64'(slot_req), 64'd0);
      chk("R9", "clamped instance takes slot 3", 64'(c_slot_req), 64'h08);
      addr = 10'h3FC;
      #1;
      chk("R9", "no strobe at window top", 64'(slot_req), 64'd0);
      chk("R8", "slot 23 outside clamped count", 64'(c_slot_req), 64'd0);
      @(negedge clk);
      valid = 1'b0; write = 1'b0;
      rd(10'h150, d, dc);
      chk("R8", "slot 2 read lane", 64'(d), 64'hC0DE_0002);
      rd(10'h100, d, dc);
      chk("R8", "slot 0 read lane", 64'(d), 64'hC0DE_0000);
      rd(10'h160, d, dc);
      chk("R9", "read past count is zero", 64'(d), 64'd0);
   endtask

   task automatic t_unmapped;
      logic [31:0] d, dc;
      rd(10'h0A0, d, dc);
      chk("R10", "unmapped read zero", 64'(d), 64'd0);
      wr(10'h011, 32'h1);
      chk("R10", "misaligned write ignored", 64'(enable), 64'd0);
      rd(10'h002, d, dc);
      chk("R10", "misaligned read zero", 64'(d), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capability();
      t_config();
      t_count_run();
      t_frozen();
      t_write_running();
      t_same_value();
      t_slots();
      t_unmapped();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule